// File: doc/BRIEF.md
# Video Control Line Filter

This block conditions the horizontal sync, vertical sync and data enable lines in the pixel-clock domain, just before they are packed into a serial link frame. A two-bit mode input selects between a plain delay line and an active filter. In either case every output lags its input by the same fixed number of clocks, so the control lines keep their alignment with the pixel data that travels beside them.

With the filter active, a new level on any line is passed on only after it has been present for three consecutive clock edges. Shorter pulses are dropped. Each line also has a transition budget over a window of 130 clocks. Horizontal sync and data enable may change twice in the window. Vertical sync may change once, which makes 130 clocks its shortest propagated pulse. A change that would overrun the budget is not lost. It is held until the window allows it, and a one-cycle flag marks the moment it was first held back.

Top module: `ctl_sig_filter`

## Requirements
- R1: While rst_ni is low, hs_o, vs_o, de_o and sup_o are all 0. After reset every line has its full transition budget, so its first qualified change is accepted without waiting.
- R2: With mode_i = 2'b00 the filter is bypassed. An input level sampled at clock edge k appears on the matching output after edge k+2. This holds for every pulse width, including single-cycle pulses.
- R3: Mode values 2'b10 and 2'b11 behave exactly like 2'b00.
- R4: With mode_i = 2'b01, an output takes a new level only when its input has shown that level at three consecutive edges, and it changes after the third of those edges. A level seen at fewer than three consecutive edges has no effect on the output. All three lines share this latency.
- R5: With mode_i = 2'b01, hs_o and de_o each change at most twice within any span of 130 edges. A further qualified change is held, and is applied once 130 edges have passed since that line's most recent accepted change.
- R6: With mode_i = 2'b01, vs_o changes at most once per 130 edges. A qualified change that comes earlier is held until 130 edges after the previous accepted change.
- R7: sup_o bit 0 (HS), bit 1 (VS) and bit 2 (DE) goes high for exactly one cycle, just after the edge at which a qualified change on that line is first held off by its budget.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00, 10 or 11: bypass; 01: filter active |
| hs_i | input | 1 | Raw horizontal sync |
| vs_i | input | 1 | Raw vertical sync |
| de_i | input | 1 | Raw data enable |
| hs_o | output | 1 | Filtered horizontal sync |
| vs_o | output | 1 | Filtered vertical sync |
| de_o | output | 1 | Filtered data enable |
| sup_o | output | 3 | Held-off pulse per line: bit 0 HS, bit 1 VS, bit 2 DE |

## Verification
The assertions assume that the raw lines and the mode are synchronous to clk_i and are settled at each rising edge. The budget check assumes that the mode changes only between whole windows, because entering bypass gives every line its budget back. The bench changes all inputs on falling edges. It changes the mode only after quiet stretches in which no change is pending, and it holds each raw level long enough that the expected result of every step can be written down in advance.

// File: rtl/ctl_filt_pkg.sv
package ctl_filt_pkg;
  typedef enum logic [1:0] {
    MODE_PASS  = 2'b00,
    MODE_FILT  = 2'b01,
    MODE_LEG_A = 2'b10,
    MODE_LEG_B = 2'b11
  } ctl_mode_e;

  localparam int NUM_CH = 3;
  localparam int CH_HS  = 0;
  localparam int CH_VS  = 1;
  localparam int CH_DE  = 2;
endpackage

// File: rtl/ctl_deglitch.sv
module ctl_deglitch #(
  parameter int STABLE_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic stable_o,
  output logic delayed_o
);
  localparam int HIST = STABLE_CYC - 1;

  logic [HIST-1:0] hist_q;
  logic [HIST:0]   win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
    end else begin
      hist_q[0] <= raw_i;
      for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  assign win       = {hist_q, raw_i};
  assign stable_o  = (&win) | ~(|win);
  assign delayed_o = hist_q[HIST-1];
endmodule

// File: rtl/ctl_rate_gate.sv
module ctl_rate_gate #(
  parameter int WINDOW = 130,
  parameter int BUDGET = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic accept_i,
  output logic allow_o
);
  localparam int CNT_W  = $clog2(WINDOW);
  localparam int USED_W = $clog2(BUDGET + 1);
  localparam int LIMIT  = WINDOW - 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [USED_W-1:0] used_q;
  logic              expired;

  assign expired = cnt_q >= CNT_W'(LIMIT);
  assign allow_o = expired || (used_q < USED_W'(BUDGET));

  // window restarts on every accepted change; saturated == budget refilled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_W'(LIMIT);
      used_q <= '0;
    end else if (clear_i) begin
      cnt_q  <= CNT_W'(LIMIT);
      used_q <= '0;
    end else if (accept_i) begin
      cnt_q  <= '0;
      used_q <= expired ? USED_W'(1) : used_q + 1'b1;
    end else if (!expired) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctl_filt_chan.sv
module ctl_filt_chan #(
  parameter int STABLE_CYC = 3,
  parameter int WINDOW     = 130,
  parameter int BUDGET     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic filt_i,
  input  logic raw_i,
  output logic out_o,
  output logic sup_o
);
  localparam int CNT_W = $clog2(WINDOW);
  localparam int LIMIT = WINDOW - 1;

  logic stable, delayed, allow;
  logic want, accept, block;
  logic out_q, out_d, held_q, sup_q;

  ctl_deglitch #(.STABLE_CYC(STABLE_CYC)) u_dg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raw_i     (raw_i),
    .stable_o  (stable),
    .delayed_o (delayed)
  );

  ctl_rate_gate #(.WINDOW(WINDOW), .BUDGET(BUDGET)) u_rg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (!filt_i),
    .accept_i (accept),
    .allow_o  (allow)
  );

  assign want   = filt_i && stable && (raw_i != out_q);
  assign accept = want && allow;
  assign block  = want && !allow;
  assign out_d  = filt_i ? (accept ? raw_i : out_q) : delayed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= 1'b0;
      held_q <= 1'b0;
      sup_q  <= 1'b0;
    end else begin
      out_q  <= out_d;
      held_q <= block;
      sup_q  <= block && !held_q;
    end
  end

  assign out_o = out_q;
  assign sup_o = sup_q;

  // edges since reset, for history-depth checks
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  if (STABLE_CYC == 3) begin : g_lat_chk
    AST_BYP_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd3 && $past(!filt_i)) |-> out_q == $past(raw_i, 3)); // R2
    AST_GLITCH_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (age_q == 2'd3 && $past(filt_i) && out_q != $past(out_q))
      |-> ($past(raw_i) == out_q && $past(raw_i, 2) == out_q && $past(raw_i, 3) == out_q)); // R4
  end

  AST_SUP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_q |=> !sup_q); // R7

  // output-side ages of the last two changes
  logic [CNT_W-1:0] agl_q, agp_q;
  logic [CNT_W-1:0] agl_inc;
  assign agl_inc = (agl_q >= CNT_W'(LIMIT)) ? agl_q : agl_q + 1'b1;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || !filt_i) begin
      agl_q <= CNT_W'(LIMIT);
      agp_q <= CNT_W'(LIMIT);
    end else if (out_d != out_q) begin
      agl_q <= '0;
      agp_q <= agl_inc;
    end else begin
      agl_q <= agl_inc;
      agp_q <= (agp_q >= CNT_W'(LIMIT)) ? agp_q : agp_q + 1'b1;
    end
  end

  if (BUDGET == 1) begin : g_rate_one
    AST_RATE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (filt_i && out_d != out_q) |-> agl_q >= CNT_W'(LIMIT)); // R6
  end else if (BUDGET == 2) begin : g_rate_two
    AST_RATE_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (filt_i && out_d != out_q) |-> agp_q >= CNT_W'(LIMIT)); // R5
  end
endmodule

// File: rtl/ctl_sig_filter.sv
module ctl_sig_filter
  import ctl_filt_pkg::*;
#(
  parameter int STABLE_CYC  = 3,
  parameter int WINDOW      = 130,
  parameter int SYNC_BUDGET = 2,
  parameter int VS_BUDGET   = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       hs_i,
  input  logic       vs_i,
  input  logic       de_i,
  output logic       hs_o,
  output logic       vs_o,
  output logic       de_o,
  output logic [2:0] sup_o
);
  logic                filt;
  logic [NUM_CH-1:0]   raw, flt, sup;

  // legacy codes share the bypass path
  assign filt = (mode_i == MODE_FILT);
  assign raw  = {de_i, vs_i, hs_i};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int BUD = (g == CH_VS) ? VS_BUDGET : SYNC_BUDGET;
    ctl_filt_chan #(
      .STABLE_CYC (STABLE_CYC),
      .WINDOW     (WINDOW),
      .BUDGET     (BUD)
    ) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .filt_i (filt),
      .raw_i  (raw[g]),
      .out_o  (flt[g]),
      .sup_o  (sup[g])
    );
  end

  assign hs_o  = flt[CH_HS];
  assign vs_o  = flt[CH_VS];
  assign de_o  = flt[CH_DE];
  assign sup_o = sup;

  AST_RST_LOW: assert property (@(posedge clk_i)
    !rst_ni |=> ({hs_o, vs_o, de_o, sup_o} == 6'b0)); // R1
endmodule

// File: tb/ctl_sig_filter_bench.sv
module ctl_sig_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       hs = 1'b0, vs = 1'b0, de = 1'b0;
  logic       hs_o, vs_o, de_o;
  logic [2:0] sup_o;
  int         n_chk = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;

  ctl_sig_filter u_ctl_sig_filter (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .mode_i (mode),
    .hs_i   (hs),
    .vs_i   (vs),
    .de_i   (de),
    .hs_o   (hs_o),
    .vs_o   (vs_o),
    .de_o   (de_o),
    .sup_o  (sup_o)
  );

  // {mode[1:0], in{hs,vs,de}, expected out{hs,vs,de}} after each edge
  localparam int NVEC = 31;
  localparam logic [7:0] VEC [NVEC] = '{
    8'b00_100_000, 8'b00_000_000, 8'b00_001_100, 8'b00_000_000,
    8'b00_010_001, 8'b00_000_000, 8'b00_000_010, 8'b00_000_000,
    8'b01_100_000, 8'b01_100_000, 8'b01_000_000, 8'b01_001_000,
    8'b01_001_000, 8'b01_001_001, 8'b01_001_001, 8'b01_100_001,
    8'b01_100_001, 8'b01_100_100, 8'b01_100_100, 8'b01_110_100,
    8'b01_110_100, 8'b01_100_100, 8'b01_100_100, 8'b10_000_100,
    8'b10_010_100, 8'b10_000_000, 8'b11_011_010, 8'b11_000_000,
    8'b11_000_011, 8'b11_000_000, 8'b11_000_000
  };

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic h, input logic v, input logic d);
    hs = h; vs = v; de = d;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0; hs = 1'b0; vs = 1'b0; de = 1'b0; mode = m;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1: outputs stay low during reset even with inputs high
    @(negedge clk);
    hs = 1'b1; vs = 1'b1; de = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", {hs_o, vs_o, de_o, sup_o}, 6'b0);
    do_reset(2'b00);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = (i < 8) ? "R2" : (i < 23) ? "R4" : "R3";
      mode = VEC[i][7:6];
      step(VEC[i][5], VEC[i][4], VEC[i][3]);
      chk(tag, {hs_o, vs_o, de_o, sup_o}, {VEC[i][2:0], 3'b000});
    end

    // R6: vertical sync, one change per window
    do_reset(2'b01);
    for (int k = 0; k <= 133; k++) begin
      step(1'b0, (k < 3), 1'b0);
      if (k == 2)   chk("R1 R6 first change", {5'b0, vs_o}, 6'd1);
      if (k == 4)   chk("R7 no pulse yet", {3'b0, sup_o}, 6'd0);
      if (k == 5)   chk("R7 vs held", {3'b0, sup_o}, 6'b000_010);
      if (k == 6)   chk("R7 single pulse", {3'b0, sup_o}, 6'd0);
      if (k == 131) chk("R6 still held", {5'b0, vs_o}, 6'd1);
      if (k == 132) chk("R6 released", {5'b0, vs_o}, 6'd0);
    end

    // R5: HS and DE allow two changes per window
    do_reset(2'b01);
    for (int k = 0; k <= 136; k++) begin
      logic lv;
      lv = (k < 3) ? 1'b1 : (k < 6) ? 1'b0 : 1'b1;
      step(lv, 1'b0, lv);
      if (k == 2)   chk("R5 first change", {4'b0, hs_o, de_o}, 6'b11);
      if (k == 5)   chk("R5 second change", {4'b0, hs_o, de_o}, 6'b00);
      if (k == 8)   chk("R7 hs de held", {hs_o, de_o, 1'b0, sup_o}, 6'b000_101);
      if (k == 9)   chk("R7 single pulse", {3'b0, sup_o}, 6'd0);
      if (k == 134) chk("R5 still held", {4'b0, hs_o, de_o}, 6'b00);
      if (k == 135) chk("R5 released", {4'b0, hs_o, de_o}, 6'b11);
    end

    summary();
  end
endmodule